// File: doc/BRIEF.md
# Pipelined Complex Multiplier with Load-Time Conjugation

This block forms the product of two complex operands, X and Y. Each operand has a 16-bit real half and a 16-bit imaginary half, both fractional two's complement with the sign in the top bit. Each operand sits in its own input register, and that register has its own active-low load enable, so one operand can stay fixed while the other streams past it. A per-operand conjugate control negates the imaginary half as it is written into the register. The conjugate therefore applies to the data captured on that same edge.

Four real multiplies follow the input registers, then one subtractor and one adder. The outputs are the full-width 32-bit real and imaginary results with a valid strobe. The valid strobe marks results that come from an edge where at least one operand was loaded. Scaling, rounding and output word selection are left to downstream logic. The pipeline is input register, product register, sum register, so the latency is fixed at three edges and the throughput is one result per cycle.

Top module: `cmul_conj_pipe`

## Requirements
- R1: While `rst` is high at a rising edge, every pipeline register clears. After that edge `res_re` and `res_im` read 0 and `res_vld` reads 0.
- R2: The X register takes `x_re`/`x_im` only on an edge where `ld_x_n` is 0, and the Y register takes `y_re`/`y_im` only on an edge where `ld_y_n` is 0. When the enable is 1, the register keeps its old contents, and the results keep using them.
- R3: If `conj_x` (or `conj_y`) is 1 on an edge where the X (or Y) register loads, the imaginary half stored on that edge is the negation of the input. On an edge where that register does not load, the control has no effect.
- R4: Conjugating an imaginary half of -32768 stores +32767, so negation never wraps.
- R5: With stored operands (a+jb) and (c+jd), `res_re` = a*c - b*d and `res_im` = a*d + b*c. Both are 32-bit two's complement, kept modulo 2^32.
- R6: Operands captured on rising edge k appear on `res_re`/`res_im` after rising edge k+2, and stay there until the next edge.
- R7: `res_vld` is 1 after edge k+2 exactly when at least one of `ld_x_n`/`ld_y_n` was 0 at edge k. Otherwise it is 0.
- R8: Loading both operands on consecutive edges gives a new, correct result after every edge, with no bubbles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x_re | input | 16 | Real half of operand X |
| x_im | input | 16 | Imaginary half of operand X |
| y_re | input | 16 | Real half of operand Y |
| y_im | input | 16 | Imaginary half of operand Y |
| ld_x_n | input | 1 | Load enable for the X register, active low |
| ld_y_n | input | 1 | Load enable for the Y register, active low |
| conj_x | input | 1 | Negate X imaginary half as it is loaded |
| conj_y | input | 1 | Negate Y imaginary half as it is loaded |
| res_re | output | 32 | Real part of the product |
| res_im | output | 32 | Imaginary part of the product |
| res_vld | output | 1 | Result comes from an edge that loaded an operand |

## Verification
Conjugation and the operand hold can meet on the same edge. One operand loads, with or without its conjugate, while the other holds; or a conjugate control is raised on an operand whose enable is inactive. A random phase drives independent enables and conjugate controls on every cycle to provoke both cases. A near-exhaustive sweep of corner values covers all four conjugate combinations, with -32768 in every position. A bench-side model of the two operand registers predicts each result arithmetically, and the bench compares it three edges later against both data outputs and the strobe.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
    // default operand component width
    localparam int CMUL_DW   = 16;
    // number of operand registers and their indices
    localparam int CMUL_NOPS = 2;
    localparam int CMUL_X    = 0;
    localparam int CMUL_Y    = 1;
endpackage

// File: rtl/cmul_operand_reg.sv
module cmul_operand_reg #(
    parameter int DW = cmul_pkg::CMUL_DW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_n,
    input  logic                 conj,
    input  logic signed [DW-1:0] re_in,
    input  logic signed [DW-1:0] im_in,
    output logic signed [DW-1:0] re_q,
    output logic signed [DW-1:0] im_q
);
    localparam logic signed [DW-1:0] MIN_V = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] MAX_V = {1'b0, {(DW-1){1'b1}}};

    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } op_t;

    op_t                  st_d, st_q;
    logic signed [DW-1:0] neg_im;

    // saturating negation of the imaginary half
    always_comb begin
        if (im_in == MIN_V) neg_im = MAX_V;
        else                neg_im = -im_in;
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (!ld_n) begin
            st_d.re = re_in;
            st_d.im = conj ? neg_im : im_in;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign re_q = st_q.re;
    assign im_q = st_q.im;

    // R2: register holds when its enable is inactive
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        ld_n |=> ($stable(re_q) && $stable(im_q)));

    // R3: a plain load stores the imaginary half unchanged
    a_r3_plain_load: assert property (@(posedge clk) disable iff (rst)
        (!ld_n && !conj) |=> (im_q == $past(im_in)));

    // R4: a conjugating load never leaves the most negative code
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!ld_n && conj) |=> (im_q != MIN_V));
endmodule

// File: rtl/cmul_prod_stage.sv
module cmul_prod_stage #(
    parameter int DW = cmul_pkg::CMUL_DW,
    localparam int PW = 2 * DW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] xr,
    input  logic signed [DW-1:0] xi,
    input  logic signed [DW-1:0] yr,
    input  logic signed [DW-1:0] yi,
    input  logic                 vld_in,
    output logic signed [PW-1:0] rr_q,
    output logic signed [PW-1:0] ii_q,
    output logic signed [PW-1:0] ri_q,
    output logic signed [PW-1:0] ir_q,
    output logic                 vld_q
);
    typedef struct packed {
        logic signed [PW-1:0] rr;
        logic signed [PW-1:0] ii;
        logic signed [PW-1:0] ri;
        logic signed [PW-1:0] ir;
        logic                 vld;
    } prod_t;

    prod_t pr_d, pr_q;

    always_comb begin
        pr_d = pr_q;
        if (rst) begin
            pr_d = '0;
        end else begin
            pr_d.rr  = PW'(xr) * PW'(yr);
            pr_d.ii  = PW'(xi) * PW'(yi);
            pr_d.ri  = PW'(xr) * PW'(yi);
            pr_d.ir  = PW'(xi) * PW'(yr);
            pr_d.vld = vld_in;
        end
    end

    always_ff @(posedge clk) begin
        pr_q <= pr_d;
    end

    assign rr_q  = pr_q.rr;
    assign ii_q  = pr_q.ii;
    assign ri_q  = pr_q.ri;
    assign ir_q  = pr_q.ir;
    assign vld_q = pr_q.vld;

    // R5: a product of two nonzero real halves carries the xor of their signs
    a_r5_rr_sign: assert property (@(posedge clk) disable iff (rst)
        (xr != 0 && yr != 0) |=> (rr_q[PW-1] == $past(xr[DW-1] ^ yr[DW-1])));
endmodule

// File: rtl/cmul_sum_stage.sv
module cmul_sum_stage #(
    parameter int DW = cmul_pkg::CMUL_DW,
    localparam int PW = 2 * DW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [PW-1:0] rr,
    input  logic signed [PW-1:0] ii,
    input  logic signed [PW-1:0] ri,
    input  logic signed [PW-1:0] ir,
    input  logic                 vld_in,
    output logic signed [PW-1:0] re_q,
    output logic signed [PW-1:0] im_q,
    output logic                 vld_q
);
    typedef struct packed {
        logic signed [PW-1:0] re;
        logic signed [PW-1:0] im;
        logic                 vld;
    } sum_t;

    sum_t sm_d, sm_q;

    always_comb begin
        sm_d = sm_q;
        if (rst) begin
            sm_d = '0;
        end else begin
            sm_d.re  = rr - ii;
            sm_d.im  = ri + ir;
            sm_d.vld = vld_in;
        end
    end

    always_ff @(posedge clk) begin
        sm_q <= sm_d;
    end

    assign re_q  = sm_q.re;
    assign im_q  = sm_q.im;
    assign vld_q = sm_q.vld;

    // R7: the strobe leaves this stage one edge after it arrived
    a_r7_vld_follow: assert property (@(posedge clk) disable iff (rst)
        vld_q == $past(vld_in));
endmodule

// File: rtl/cmul_conj_pipe.sv
module cmul_conj_pipe #(
    parameter int DW = cmul_pkg::CMUL_DW,
    localparam int PW = 2 * DW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] x_re,
    input  logic signed [DW-1:0] x_im,
    input  logic signed [DW-1:0] y_re,
    input  logic signed [DW-1:0] y_im,
    input  logic                 ld_x_n,
    input  logic                 ld_y_n,
    input  logic                 conj_x,
    input  logic                 conj_y,
    output logic signed [PW-1:0] res_re,
    output logic signed [PW-1:0] res_im,
    output logic                 res_vld
);
    localparam int NOPS = cmul_pkg::CMUL_NOPS;
    localparam int IX   = cmul_pkg::CMUL_X;
    localparam int IY   = cmul_pkg::CMUL_Y;

    logic signed [DW-1:0] in_re [NOPS];
    logic signed [DW-1:0] in_im [NOPS];
    logic signed [DW-1:0] op_re [NOPS];
    logic signed [DW-1:0] op_im [NOPS];
    logic [NOPS-1:0]      ld_n_v;
    logic [NOPS-1:0]      conj_v;

    assign in_re[IX]  = x_re;
    assign in_im[IX]  = x_im;
    assign in_re[IY]  = y_re;
    assign in_im[IY]  = y_im;
    assign ld_n_v[IX] = ld_x_n;
    assign ld_n_v[IY] = ld_y_n;
    assign conj_v[IX] = conj_x;
    assign conj_v[IY] = conj_y;

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        cmul_operand_reg #(.DW(DW)) u_op (
            .clk   (clk),
            .rst   (rst),
            .ld_n  (ld_n_v[g]),
            .conj  (conj_v[g]),
            .re_in (in_re[g]),
            .im_in (in_im[g]),
            .re_q  (op_re[g]),
            .im_q  (op_im[g])
        );
    end

    // strobe for the input-register stage
    logic ld_vld_d, ld_vld_q;

    always_comb begin
        ld_vld_d = ld_vld_q;
        if (rst) ld_vld_d = 1'b0;
        else     ld_vld_d = ~&ld_n_v;
    end

    always_ff @(posedge clk) begin
        ld_vld_q <= ld_vld_d;
    end

    logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
    logic                 p_vld;

    cmul_prod_stage #(.DW(DW)) u_prod (
        .clk    (clk),
        .rst    (rst),
        .xr     (op_re[IX]),
        .xi     (op_im[IX]),
        .yr     (op_re[IY]),
        .yi     (op_im[IY]),
        .vld_in (ld_vld_q),
        .rr_q   (p_rr),
        .ii_q   (p_ii),
        .ri_q   (p_ri),
        .ir_q   (p_ir),
        .vld_q  (p_vld)
    );

    cmul_sum_stage #(.DW(DW)) u_sum (
        .clk    (clk),
        .rst    (rst),
        .rr     (p_rr),
        .ii     (p_ii),
        .ri     (p_ri),
        .ir     (p_ir),
        .vld_in (p_vld),
        .re_q   (res_re),
        .im_q   (res_im),
        .vld_q  (res_vld)
    );

    // R7: no operand loaded means no strobe entering the pipe
    a_r7_no_load_no_vld: assert property (@(posedge clk) disable iff (rst)
        (ld_x_n && ld_y_n) |=> !ld_vld_q);
endmodule

// File: tb/cmul_conj_pipe_test.sv
`timescale 1ns/1ps
module cmul_conj_pipe_test;
    localparam int DW = 16;
    localparam int PW = 32;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic signed [DW-1:0] x_re = '0, x_im = '0, y_re = '0, y_im = '0;
    logic                 ld_x_n = 1'b1, ld_y_n = 1'b1;
    logic                 conj_x = 1'b0, conj_y = 1'b0;
    logic signed [PW-1:0] res_re, res_im;
    logic                 res_vld;

    always #10 clk = ~clk;

    cmul_conj_pipe #(.DW(DW)) uut (
        .clk(clk), .rst(rst),
        .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
        .ld_x_n(ld_x_n), .ld_y_n(ld_y_n), .conj_x(conj_x), .conj_y(conj_y),
        .res_re(res_re), .res_im(res_im), .res_vld(res_vld)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // bench model of the stored operands
    logic signed [DW-1:0] m_xr = '0, m_xi = '0, m_yr = '0, m_yi = '0;
    // expected-result pipeline, index 1..3
    logic signed [PW-1:0] p_re [4];
    logic signed [PW-1:0] p_im [4];
    logic                 p_vld [4];
    string                p_tag [4];

    function automatic logic signed [DW-1:0] neg_sat(input logic signed [DW-1:0] v);
        if (v == -16'sd32768) return 16'sd32767;
        return -v;
    endfunction

    task automatic check(input string tag,
                         input logic signed [PW-1:0] gr, input logic signed [PW-1:0] er,
                         input logic signed [PW-1:0] gi, input logic signed [PW-1:0] ei,
                         input logic gv, input logic ev);
        n_run++;
        if (gr !== er || gi !== ei || gv !== ev) begin
            n_fail++;
            $display("FAIL %s: re=%0d exp %0d, im=%0d exp %0d, vld=%0b exp %0b",
                     tag, gr, er, gi, ei, gv, ev);
        end
    endtask

    // one cycle: check the oldest prediction, then drive new inputs
    task automatic cyc(input logic signed [DW-1:0] xr, input logic signed [DW-1:0] xi,
                       input logic signed [DW-1:0] yr, input logic signed [DW-1:0] yi,
                       input logic lxn, input logic lyn, input logic cx, input logic cy,
                       input string tag);
        logic signed [63:0] wr, wi;
        @(negedge clk);
        check(p_tag[3], res_re, p_re[3], res_im, p_im[3], res_vld, p_vld[3]);
        p_re[3] = p_re[2]; p_im[3] = p_im[2]; p_vld[3] = p_vld[2]; p_tag[3] = p_tag[2];
        p_re[2] = p_re[1]; p_im[2] = p_im[1]; p_vld[2] = p_vld[1]; p_tag[2] = p_tag[1];
        x_re = xr; x_im = xi; y_re = yr; y_im = yi;
        ld_x_n = lxn; ld_y_n = lyn; conj_x = cx; conj_y = cy;
        if (!lxn) begin m_xr = xr; m_xi = cx ? neg_sat(xi) : xi; end
        if (!lyn) begin m_yr = yr; m_yi = cy ? neg_sat(yi) : yi; end
        wr = 64'(m_xr) * 64'(m_yr) - 64'(m_xi) * 64'(m_yi);
        wi = 64'(m_xr) * 64'(m_yi) + 64'(m_xi) * 64'(m_yr);
        p_re[1]  = wr[PW-1:0];
        p_im[1]  = wi[PW-1:0];
        p_vld[1] = !lxn || !lyn;
        p_tag[1] = tag;
    endtask

    logic signed [DW-1:0] vals [8];

    initial begin
        vals[0] = -16'sd32768; vals[1] = -16'sd32767; vals[2] = -16'sd1; vals[3] = 16'sd0;
        vals[4] = 16'sd1;      vals[5] = 16'sd32767;  vals[6] = 16'sd12345; vals[7] = -16'sd23456;
        for (int i = 0; i < 4; i++) begin
            p_re[i] = '0; p_im[i] = '0; p_vld[i] = 1'b0; p_tag[i] = "R1";
        end

        // R1: reset state
        repeat (5) @(negedge clk);
        check("R1", res_re, '0, res_im, '0, res_vld, 1'b0);
        rst = 1'b0;

        // R5 R3 R4 R8: back-to-back sweep of corner values, all conjugate combos
        for (int c = 0; c < 4; c++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    for (int d = 0; d < 8; d++) begin
                        for (int e = 0; e < 8; e++) begin
                            string t;
                            if ((c[0] && b == 0) || (c[1] && e == 0)) t = "R4";
                            else if (c != 0)                           t = "R3";
                            else if (a == b)                           t = "R8";
                            else                                       t = "R5";
                            cyc(vals[a], vals[b], vals[d], vals[e], 1'b0, 1'b0, c[0], c[1], t);
                        end
                    end
                end
            end
        end

        // R6: lone load followed by idle cycles
        cyc(16'sd300, -16'sd700, 16'sd1100, 16'sd90, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
        repeat (4) cyc('0, '0, '0, '0, 1'b1, 1'b1, 1'b0, 1'b0, "R7");

        // R2 R3 R7: independent random enables, conjugates and data
        for (int k = 0; k < 2000; k++) begin
            logic [31:0] r1, r2, r3;
            logic lxn, lyn, cx, cy;
            string t;
            r1 = $urandom; r2 = $urandom; r3 = $urandom;
            lxn = r3[0]; lyn = r3[1]; cx = r3[2]; cy = r3[3];
            if ((lxn && cx) || (lyn && cy)) t = "R3";
            else if (lxn && lyn)            t = "R7";
            else                            t = "R2";
            cyc(r1[15:0], r1[31:16], r2[15:0], r2[31:16], lxn, lyn, cx, cy, t);
        end

        // drain the pipe
        repeat (3) cyc('0, '0, '0, '0, 1'b1, 1'b1, 1'b0, 1'b0, "R7");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R6: watchdog expired, cycles=100000 expected completion earlier");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule